// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data word per request into an asynchronous serial frame on a single output line. A one-cycle start strobe hands it a word of up to nine bits together with a frame configuration. The configuration sets the data width, the parity scheme, the stop length, the bit order and two polarity options. The block captures the word and the configuration in that cycle, raises busy, and then shifts the frame out. The frame is advanced by a clock-enable tick that runs at sixteen times the bit rate.

A frame is a start bit, then the data bits, then an optional parity bit, then a stop period. The line rests at the stop level between frames. The stop period can last half, one, one and a half or two bit times, so that a transmitter can match slow or unusual receivers. Polarity can be flipped for the whole line, or for the data and parity bits only. A new request is taken only when busy is low.

Top module: `sertx_top`

## Requirements
- R1: Out of reset `line_o` is 1 and `busy_o` is 0. While no frame is in progress, `line_o` is the inverse of `inv_line_i`, one cycle late.
- R2: A frame is sent in this order: a start bit of logical 0, the data bits, the parity bit if one is enabled, and then the stop period at logical 1.
- R3: The `width_i` value sets the number of data bits from 5 to 9. Values below 5 act as 5 and values above 9 act as 9.
- R4: Data bits go least significant first when `msb_first_i` is 0. When it is 1, bit width-1 goes first and bit 0 goes last.
- R5: Parity is selected by `parity_i`: 1 gives odd (data ones plus the parity bit is odd), 2 gives even, 3 gives a constant 1, 4 gives a constant 0, and 0 or 5 to 7 give no parity bit. Only the sent data bits are counted.
- R6: The stop period is selected by `stop_i`: 0 gives 16 ticks, 1 gives 24 ticks, 2 gives 32 ticks and 3 gives 8 ticks.
- R7: Every start, data and parity bit lasts exactly 16 ticks. Nothing moves in a cycle where `tick_i` is 0.
- R8: With `inv_line_i` set, every level on the line is inverted, so the idle and stop level is 0 and the start bit is 1.
- R9: With `inv_data_i` set, the data and parity bits are inverted. The start and stop bits keep their normal polarity. The parity value is worked out from the data before it is inverted.
- R10: `busy_o` rises in the cycle after an accepted start strobe. It falls on the clock edge where the last stop tick is counted, and the line then stays at the stop level.
- R11: A start strobe seen while `busy_o` is 1 is ignored. The data and configuration inputs are captured at acceptance, so later changes do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable at 16 times the bit rate |
| start_i | input | 1 | Request to send one frame |
| data_i | input | 9 | Word to send; the upper bits are ignored for narrower widths |
| width_i | input | 4 | Number of data bits (clamped to 5..9) |
| parity_i | input | 3 | Parity scheme code |
| stop_i | input | 2 | Stop length code |
| msb_first_i | input | 1 | Send the most significant data bit first |
| inv_line_i | input | 1 | Invert every level on the line |
| inv_data_i | input | 1 | Invert only the data and parity bits |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default parameters: nine data bits at most, a minimum width of five and sixteen ticks per bit. These defaults keep the full configuration space small, so the bench sweeps every width against every parity code and every stop length. It rotates the bit order and both inversion options through that sweep, then crosses order and inversion completely at full width. It also covers out-of-range width codes and frames driven with a sparse tick. In every frame the bench fires a start strobe in the middle and scrambles all the inputs. This shows that capture at acceptance holds for each format, and that the expected line level can be worked out tick by tick from the tick count alone.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // parity scheme codes on parity_i
    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    // stop length codes on stop_i
    localparam logic [1:0] STOP_ONE     = 2'd0;
    localparam logic [1:0] STOP_ONEHALF = 2'd1;
    localparam logic [1:0] STOP_TWO     = 2'd2;
    localparam logic [1:0] STOP_HALF    = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_STOP = 2'd2
    } tx_state_e;

endpackage

// File: rtl/sertx_cfg_norm.sv
module sertx_cfg_norm #(
    parameter int DATA_W = 9,
    parameter int MIN_W  = 5,
    parameter int OVS    = 16,
    localparam int WSEL_W = $clog2(DATA_W + 1),
    localparam int STOP_W = $clog2(2 * OVS + 1)
) (
    input  logic [WSEL_W-1:0] width_req,
    input  logic [1:0]        stop_req,
    output logic [WSEL_W-1:0] width_eff,
    output logic [STOP_W-1:0] stop_ticks
);
    import sertx_pkg::*;

    always_comb begin
        if (width_req < WSEL_W'(MIN_W)) begin
            width_eff = WSEL_W'(MIN_W);
        end else if (width_req > WSEL_W'(DATA_W)) begin
            width_eff = WSEL_W'(DATA_W);
        end else begin
            width_eff = width_req;
        end
    end

    always_comb begin
        unique case (stop_req)
            STOP_ONE:     stop_ticks = STOP_W'(OVS);
            STOP_ONEHALF: stop_ticks = STOP_W'(OVS + OVS / 2);
            STOP_TWO:     stop_ticks = STOP_W'(2 * OVS);
            default:      stop_ticks = STOP_W'(OVS / 2);
        endcase
    end

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DATA_W = 9,
    localparam int WSEL_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [WSEL_W-1:0] width,
    input  logic [2:0]        mode,
    output logic              par_bit,
    output logic              par_en
);
    import sertx_pkg::*;

    logic ones_odd;

    // xor over the bits that are actually sent
    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(width)) begin
                ones_odd = ones_odd ^ data[i];
            end
        end
    end

    always_comb begin
        par_en  = 1'b1;
        par_bit = 1'b0;
        unique case (mode)
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_EVEN:  par_bit = ones_odd;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
    parameter int DATA_W = 9,
    localparam int WSEL_W  = $clog2(DATA_W + 1),
    localparam int FRAME_W = DATA_W + 2,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [WSEL_W-1:0]  width,
    input  logic               msb_first,
    input  logic               inv_data,
    input  logic               par_bit,
    input  logic               par_en,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   last_idx
);
    logic [DATA_W-1:0] ordered;

    // reorder the data bits so that ordered[0] is sent first
    for (genvar g = 0; g < DATA_W; g++) begin : g_order
        logic [WSEL_W-1:0] mirror;
        always_comb begin
            mirror     = width - WSEL_W'(1) - WSEL_W'(g);
            ordered[g] = 1'b0;
            if (g < int'(width)) begin
                ordered[g] = msb_first ? data[mirror] : data[g];
            end
        end
    end

    // bit 0 is the start bit in logical polarity; the line stage inverts it when asked
    always_comb begin
        frame    = '0;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(width)) begin
                frame[i + 1] = ordered[i] ^ inv_data;
            end
        end
        if (par_en) begin
            frame[int'(width) + 1] = par_bit ^ inv_data;
        end
        last_idx = IDX_W'(int'(width) + (par_en ? 1 : 0));
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W = 9,
    parameter int MIN_W  = 5,
    parameter int OVS    = 16,
    localparam int WSEL_W  = $clog2(DATA_W + 1),
    localparam int STOP_W  = $clog2(2 * OVS + 1),
    localparam int FRAME_W = DATA_W + 2,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [WSEL_W-1:0] width_i,
    input  logic [2:0]        parity_i,
    input  logic [1:0]        stop_i,
    input  logic              msb_first_i,
    input  logic              inv_line_i,
    input  logic              inv_data_i,
    output logic              line_o,
    output logic              busy_o
);
    import sertx_pkg::*;

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] shreg;
        logic [STOP_W-1:0]  tcnt;
        logic [IDX_W-1:0]   bits_left;
        logic [STOP_W-1:0]  stop_len;
        logic               inv_line;
        logic               line;
    } tx_reg_t;

    tx_reg_t q, d;

    logic [WSEL_W-1:0]  width_eff;
    logic [STOP_W-1:0]  stop_ticks;
    logic               par_bit;
    logic               par_en;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   last_idx;

    sertx_cfg_norm #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OVS(OVS)) u_cfg (
        .width_req (width_i),
        .stop_req  (stop_i),
        .width_eff (width_eff),
        .stop_ticks(stop_ticks)
    );

    sertx_parity #(.DATA_W(DATA_W)) u_par (
        .data   (data_i),
        .width  (width_eff),
        .mode   (parity_i),
        .par_bit(par_bit),
        .par_en (par_en)
    );

    sertx_framer #(.DATA_W(DATA_W)) u_frm (
        .data     (data_i),
        .width    (width_eff),
        .msb_first(msb_first_i),
        .inv_data (inv_data_i),
        .par_bit  (par_bit),
        .par_en   (par_en),
        .frame    (frame),
        .last_idx (last_idx)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.line = ~inv_line_i;
                if (start_i) begin
                    d.st        = ST_BITS;
                    d.shreg     = frame;
                    d.tcnt      = '0;
                    d.bits_left = last_idx;
                    d.stop_len  = stop_ticks;
                    d.inv_line  = inv_line_i;
                    d.line      = frame[0] ^ inv_line_i;
                end
            end
            ST_BITS: begin
                if (tick_i) begin
                    if (q.tcnt == STOP_W'(OVS - 1)) begin
                        d.tcnt = '0;
                        if (q.bits_left == '0) begin
                            d.st   = ST_STOP;
                            d.line = ~q.inv_line;
                        end else begin
                            d.shreg     = q.shreg >> 1;
                            d.bits_left = q.bits_left - IDX_W'(1);
                            d.line      = q.shreg[1] ^ q.inv_line;
                        end
                    end else begin
                        d.tcnt = q.tcnt + STOP_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (q.tcnt == q.stop_len - STOP_W'(1)) begin
                        d.st   = ST_IDLE;
                        d.tcnt = '0;
                    end else begin
                        d.tcnt = q.tcnt + STOP_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.shreg     <= '0;
            q.tcnt      <= '0;
            q.bits_left <= '0;
            q.stop_len  <= '0;
            q.inv_line  <= 1'b0;
            q.line      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.line;
    assign busy_o = (q.st != ST_IDLE);

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o) else $error("busy did not rise"); // R10

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (line_o == $past(inv_line_i))) else $error("start level"); // R8

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy_o && !$past(busy_o)) |-> (line_o == !$past(inv_line_i)))
        else $error("idle level"); // R1

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> (busy_o && $stable(line_o))) else $error("moved without tick"); // R7

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tick_i) |=> $stable(q.bits_left)) else $error("start taken while busy"); // R11

endmodule

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] data_i = '0;
    logic [3:0] width_i = 4'd8;
    logic [2:0] parity_i = '0;
    logic [1:0] stop_i = '0;
    logic       msb_first_i = 1'b0;
    logic       inv_line_i = 1'b0;
    logic       inv_data_i = 1'b0;
    logic       line_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
        .data_i(data_i), .width_i(width_i), .parity_i(parity_i), .stop_i(stop_i),
        .msb_first_i(msb_first_i), .inv_line_i(inv_line_i), .inv_data_i(inv_data_i),
        .line_o(line_o), .busy_o(busy_o)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // send one frame and compare line and busy every cycle against a tick count
    task automatic run_frame(input int wc, input int pc, input int sc, input bit msb,
                             input bit il, input bit id, input logic [8:0] dat, input int tper);
        int w, nb, stp, total, k, p, idx;
        bit pen, pv, ones, eb, el, eb_busy;
        string tag;
        w = (wc < 5) ? 5 : ((wc > 9) ? 9 : wc);
        ones = 1'b0;
        for (int i = 0; i < w; i++) ones ^= dat[i];
        pen = 1'b1;
        case (pc)
            1: pv = ~ones;
            2: pv = ones;
            3: pv = 1'b1;
            4: pv = 1'b0;
            default: begin pen = 1'b0; pv = 1'b0; end
        endcase
        nb = 1 + w + (pen ? 1 : 0);
        stp = (sc == 0) ? 16 : (sc == 1) ? 24 : (sc == 2) ? 32 : 8;
        total = nb * 16 + stp;

        @(negedge clk);
        data_i = dat; width_i = 4'(wc); parity_i = 3'(pc); stop_i = 2'(sc);
        msb_first_i = msb; inv_line_i = il; inv_data_i = id;
        start_i = 1'b1;
        tick_i = 1'b1;
        @(posedge clk);
        k = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            p = k / 16;
            if (k >= total) begin
                el = ~il; eb_busy = 1'b0; tag = "R1 R10 idle after stop";
            end else if (k >= nb * 16) begin
                el = ~il; eb_busy = 1'b1; tag = "R6 R8 stop";
            end else if (p == 0) begin
                el = il; eb_busy = 1'b1; tag = "R2 R7 R8 start";
            end else if (p <= w) begin
                idx = msb ? (w - p) : (p - 1);
                eb = dat[idx] ^ id;
                el = eb ^ il; eb_busy = 1'b1; tag = "R3 R4 R9 data";
            end else begin
                eb = pv ^ id;
                el = eb ^ il; eb_busy = 1'b1; tag = "R5 R9 parity";
            end
            check(line_o, el, tag);
            check(busy_o, eb_busy, (k >= total) ? "R10 busy low" : "R10 R11 busy high");
            if (k >= total + 2) break;
            start_i = (c == 20);
            if (k + 3 < total) begin
                data_i = ~dat; width_i = 4'(13 - wc); parity_i = 3'(pc + 3);
                stop_i = 2'(sc + 1); msb_first_i = ~msb; inv_line_i = ~il; inv_data_i = ~id;
            end else begin
                data_i = dat; width_i = 4'(wc); parity_i = 3'(pc); stop_i = 2'(sc);
                msb_first_i = msb; inv_line_i = il; inv_data_i = id;
            end
            tick_i = ((c % tper) == 0);
            @(posedge clk);
            if (tick_i) k++;
        end
        start_i = 1'b0;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(line_o, 1'b1, "R1 reset line");
        check(busy_o, 1'b0, "R1 reset busy");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(line_o, 1'b1, "R1 idle high");
        inv_line_i = 1'b1;
        @(negedge clk);
        check(line_o, 1'b0, "R1 R8 idle follows inversion");
        inv_line_i = 1'b0;
        @(negedge clk);
        check(line_o, 1'b1, "R1 idle restored");

        // every width x parity code x stop code, order and inversions rotated
        for (int w = 5; w <= 9; w++)
            for (int pc = 0; pc < 5; pc++)
                for (int sc = 0; sc < 4; sc++) begin
                    int n;
                    n = w * 20 + pc * 4 + sc;
                    run_frame(w, pc, sc, n[0], n[1], n[2], 9'((n * 37 + 11) ^ (n << 3)), 1);
                end
        // full order x inversion cross at full width
        for (int m = 0; m < 8; m++)
            run_frame(9, 1 + (m % 4), m % 4, m[0], m[1], m[2], 9'(9'h1A5 ^ (m * 73)), 1);
        // clamped width codes and unused parity codes
        run_frame(2, 6, 0, 1'b0, 1'b0, 1'b0, 9'h0FF, 1);
        run_frame(15, 2, 3, 1'b1, 1'b0, 1'b1, 9'h15A, 1);
        run_frame(0, 7, 1, 1'b0, 1'b1, 1'b0, 9'h1E3, 1);
        // sparse tick
        run_frame(7, 1, 3, 1'b0, 1'b0, 1'b0, 9'h05B, 3);
        run_frame(8, 3, 1, 1'b1, 1'b1, 1'b1, 9'h0C4, 2);
        run_frame(5, 4, 2, 1'b0, 1'b0, 1'b1, 9'h013, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule